// File: doc/BRIEF.md
# Indirect Address Update Unit

This block serves the register-indirect storage and I/O byte transfer instructions of a small microcoded processor. For each request it takes the current value of a pointer register, a 4-bit modifier, a byte/halfword flag, a load/store flag and the indices of the data and pointer registers. One cycle later it presents the storage address to use, the post-modified pointer value, and the control bits that the register file needs: whether to write the pointer back, whether fetched data takes priority over that write-back, and whether the destination high byte must be cleared.

The storage access always uses the pointer as it was before modification. The modifier selects a post-increment by 1 to 4, a post-decrement by 1 to 4, or no change. Halfword accesses are kept on even addresses, and an odd pointer on a halfword access is reported.

Top module: `iau_top`

## Requirements
- R1: For a byte access, `addr_o` equals the pointer value presented with the request, before any modification.
- R2: Modifier codes 0, 1, 2, 3 make `ptr_next_o` the request pointer plus 1, 2, 3, 4 respectively.
- R3: Modifier codes 4, 5, 6, 7 make `ptr_next_o` the request pointer minus 1, 2, 3, 4 respectively.
- R4: Modifier codes 8 to 15 make `ptr_next_o` equal to the request pointer and keep `ptr_we_o` low.
- R5: For modifier codes 0 to 7, `ptr_we_o` is high unless R6 applies; this includes stores whose data and pointer indices match.
- R6: On a load (`load_i`=1) whose `data_idx_i` equals `ptr_idx_i`, `ptr_we_o` is low and `data_wins_o` is high; `data_wins_o` is low in every other case.
- R7: `hi_clr_o` is high only for a byte load (`byte_i`=1, `load_i`=1).
- R8: For a halfword access (`byte_i`=0), `addr_o` bit 0 is 0 and its upper bits follow the pointer; `align_err_o` is high for that request exactly when the pointer bit 0 is 1, and never on byte accesses.
- R9: Pointer arithmetic wraps modulo 2^16 (FFFF plus 1 gives 0000; 0000 minus 1 gives FFFF).
- R10: Results appear with `vld_o` high in the cycle after `req_i` is sampled high; with no request, and in reset, `vld_o`, `ptr_we_o`, `hi_clr_o`, `data_wins_o` and `align_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| mod_i | input | 4 | Pointer modifier code |
| ptr_i | input | 16 | Pointer register value |
| byte_i | input | 1 | 1 = byte access, 0 = halfword access |
| load_i | input | 1 | 1 = load into a register, 0 = store or transfer out |
| data_idx_i | input | 4 | Data register index |
| ptr_idx_i | input | 4 | Pointer register index |
| vld_o | output | 1 | Result valid |
| addr_o | output | 16 | Storage address |
| ptr_next_o | output | 16 | Post-modified pointer |
| ptr_we_o | output | 1 | Pointer write-back enable |
| data_wins_o | output | 1 | Loaded data overrides pointer write-back |
| hi_clr_o | output | 1 | Clear destination high byte |
| align_err_o | output | 1 | Odd pointer on halfword access |

## Verification
The embedded assertions watch, on every cycle, that a byte address matches the pointer sampled a cycle earlier, that halfword addresses stay even, that a hold modifier or a same-register load never raises write-back, and that the control flags only appear with a valid result. The exact increment and decrement amounts, the wrap at both ends of the 16-bit range, the store case with matching indices and the byte-load high-byte clear are shown only by the bench's scenarios, which compare each result against values computed from the requirements.

// File: rtl/iau_pkg.sv
package iau_pkg;
  localparam int unsigned MOD_W = 4;
  localparam int unsigned MAG_W = 3;

  typedef struct packed {
    logic             neg;
    logic [MAG_W-1:0] mag;
  } step_t;
endpackage

// File: rtl/iau_step_dec.sv
module iau_step_dec
  import iau_pkg::*;
(
  input  logic [MOD_W-1:0] mod_i,
  output step_t            step_o,
  output logic             hold_o
);
  always_comb begin
    hold_o      = mod_i[3];
    step_o.neg  = mod_i[2];
    step_o.mag  = hold_o ? '0 : MAG_W'({1'b0, mod_i[1:0]}) + MAG_W'(1);
  end
endmodule

// File: rtl/iau_ptr_add.sv
module iau_ptr_add
  import iau_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] ptr_i,
  input  step_t         step_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ext;

  always_comb begin
    ext   = AW'(step_i.mag);
    // modulo 2^AW wrap is intended
    ptr_o = step_i.neg ? ptr_i - ext : ptr_i + ext;
  end
endmodule

// File: rtl/iau_align.sv
module iau_align #(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] ptr_i,
  input  logic          byte_i,
  output logic [AW-1:0] addr_o,
  output logic          misalign_o
);
  always_comb begin
    addr_o     = ptr_i;
    misalign_o = 1'b0;
    if (!byte_i) begin
      addr_o[0]  = 1'b0;
      misalign_o = ptr_i[0];
    end
  end
endmodule

// File: rtl/iau_top.sv
module iau_top
  import iau_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned IDXW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic [AW-1:0]    ptr_i,
  input  logic             byte_i,
  input  logic             load_i,
  input  logic [IDXW-1:0]  data_idx_i,
  input  logic [IDXW-1:0]  ptr_idx_i,
  output logic             vld_o,
  output logic [AW-1:0]    addr_o,
  output logic [AW-1:0]    ptr_next_o,
  output logic             ptr_we_o,
  output logic             data_wins_o,
  output logic             hi_clr_o,
  output logic             align_err_o
);
  step_t         step;
  logic          hold;
  logic [AW-1:0] ptr_mod;
  logic [AW-1:0] addr_c;
  logic          misalign;
  logic          same_ld;

  iau_step_dec u_dec (
    .mod_i  (mod_i),
    .step_o (step),
    .hold_o (hold)
  );

  iau_ptr_add #(.AW(AW)) u_add (
    .ptr_i  (ptr_i),
    .step_i (step),
    .ptr_o  (ptr_mod)
  );

  iau_align #(.AW(AW)) u_align (
    .ptr_i      (ptr_i),
    .byte_i     (byte_i),
    .addr_o     (addr_c),
    .misalign_o (misalign)
  );

  assign same_ld = load_i && (data_idx_i == ptr_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o       <= 1'b0;
      addr_o      <= '0;
      ptr_next_o  <= '0;
      ptr_we_o    <= 1'b0;
      data_wins_o <= 1'b0;
      hi_clr_o    <= 1'b0;
      align_err_o <= 1'b0;
    end else begin
      vld_o       <= req_i;
      addr_o      <= addr_c;
      ptr_next_o  <= ptr_mod;
      ptr_we_o    <= req_i && !hold && !same_ld;
      data_wins_o <= req_i && same_ld;
      hi_clr_o    <= req_i && load_i && byte_i;
      align_err_o <= req_i && misalign;
    end
  end

  AST_BYTE_ADDR_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && $past(byte_i) |-> addr_o == $past(ptr_i)); // R1
  AST_HOLD_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && $past(mod_i[3]) |-> !ptr_we_o); // R4
  AST_SAME_LOAD_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && $past(load_i && (data_idx_i == ptr_idx_i)) |-> !ptr_we_o && data_wins_o); // R6
  AST_HALF_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && !$past(byte_i) |-> !addr_o[0]); // R8
  AST_FLAGS_NEED_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> !(ptr_we_o || data_wins_o || hi_clr_o || align_err_o)); // R10
  AST_WB_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ptr_we_o && data_wins_o)); // R5
endmodule

// File: tb/tb_iau_top.sv
module tb_iau_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [3:0]  mod = '0;
  logic [15:0] ptr = '0;
  logic        byt = 1'b0;
  logic        ld = 1'b0;
  logic [3:0]  didx = '0;
  logic [3:0]  pidx = '0;

  logic        vld, we, dw, hc, ae;
  logic [15:0] addr, pnext;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct packed {
    logic [15:0] addr;
    logic [15:0] pnext;
    logic        we;
    logic        dw;
    logic        hc;
    logic        ae;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  iau_top dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mod_i(mod), .ptr_i(ptr),
    .byte_i(byt), .load_i(ld), .data_idx_i(didx), .ptr_idx_i(pidx),
    .vld_o(vld), .addr_o(addr), .ptr_next_o(pnext), .ptr_we_o(we),
    .data_wins_o(dw), .hi_clr_o(hc), .align_err_o(ae)
  );

  // driver: compute expectation from the requirements, then drive one request
  task automatic issue(input string tag, input int m, input int p, input bit b,
                       input bit l, input int di, input int pi);
    exp_t e;
    int   delta;
    if (m < 4)      delta = m + 1;           // R2
    else if (m < 8) delta = -(m - 3);        // R3
    else            delta = 0;               // R4
    e.pnext = 16'((p + delta + 65536) % 65536); // R9
    e.addr  = b ? 16'(p) : (16'(p) & 16'hFFFE);
    e.ae    = !b && (p % 2 == 1);
    e.dw    = l && (di == pi);
    e.we    = (m < 8) && !e.dw;
    e.hc    = b && l;
    @(negedge clk);
    req = 1'b1; mod = 4'(m); ptr = 16'(p); byt = b; ld = l;
    didx = 4'(di); pidx = 4'(pi);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      req = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && vld) begin
      exp_t  e;
      exp_t  a;
      string t;
      a = '{addr, pnext, we, dw, hc, ae};
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R10 unexpected vld actual=%h expected=none", a);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s actual addr=%h pn=%h we=%b dw=%b hc=%b ae=%b expected addr=%h pn=%h we=%b dw=%b hc=%b ae=%b",
                   t, a.addr, a.pnext, a.we, a.dw, a.hc, a.ae,
                   e.addr, e.pnext, e.we, e.dw, e.hc, e.ae);
        end
      end
    end
  end

  task automatic check_quiet(input string tag);
    @(negedge clk);
    n_chk++;
    if ({vld, we, dw, hc, ae} !== 5'b0) begin
      n_bad++;
      $display("FAIL %s actual flags=%b expected=00000", tag, {vld, we, dw, hc, ae});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_quiet("R10 reset");
    rst_n = 1'b1;
    check_quiet("R10 idle after reset");

    issue("R1 R2 byte +1", 0, 16'h1234, 1, 0, 2, 3);
    issue("R2 +2",         1, 16'h1235, 1, 1, 2, 3);
    issue("R2 +3",         2, 16'h0100, 0, 0, 5, 6);
    issue("R2 +4",         3, 16'h0100, 1, 0, 5, 6);
    issue("R3 -1",         4, 16'h0200, 1, 0, 1, 2);
    issue("R3 -2",         5, 16'h0200, 0, 1, 1, 2);
    issue("R3 -3",         6, 16'h0200, 1, 1, 1, 2);
    issue("R3 -4",         7, 16'h0200, 0, 0, 1, 2);
    issue("R4 hold 8",     8, 16'h4444, 1, 0, 1, 2);
    issue("R4 hold F",    15, 16'h5555, 1, 1, 1, 2);
    issue("R6 same load", 2, 16'h0300, 0, 1, 7, 7);
    issue("R5 same store",2, 16'h0300, 0, 0, 7, 7);
    issue("R7 byte load", 4, 16'h00FF, 1, 1, 3, 9);
    issue("R8 odd half",  0, 16'hABCD, 0, 1, 3, 9);
    issue("R8 odd byte",  0, 16'hABCD, 1, 0, 3, 9);
    issue("R9 wrap up",   0, 16'hFFFF, 1, 0, 0, 1);
    issue("R9 wrap up4",  3, 16'hFFFE, 0, 0, 0, 1);
    issue("R9 wrap down", 4, 16'h0000, 1, 0, 0, 1);
    issue("R9 wrap dn4",  7, 16'h0002, 0, 1, 0, 1);
    idle(1);
    check_quiet("R10 idle gap");
    for (int i = 0; i < 16; i++)
      issue("R2 R3 R4 sweep", i, 16'h8000 + i * 7, i[0], i[1], i % 3, i % 5);
    idle(2);
    check_quiet("R10 drained");
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R10 missing results actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule